// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This unit treats two 64-bit operands as vectors of independent lanes and adds or subtracts them lane by lane. The lanes are 8, 16 or 32 bits wide. Each lane result either wraps modulo the lane width or is clamped to the signed or unsigned range of the lane. The same lane datapath also builds compare masks: equality, or signed greater-than, of A against B. Each lane of the mask comes out as all ones or all zeros.

Operands and controls are taken in on each rising clock edge. The result appears on `result_o` one cycle later, from a single output register with an asynchronous active-low reset. Carries never cross a lane boundary. The saturating modes apply to the 8- and 16-bit lane sizes only.

Top module: `psat_addsub_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o` is zero. Otherwise `result_o` holds the result for the inputs sampled at the previous rising edge of `clk_i`.
- R2: The lane size is set by `lane_sel_i`: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. With `cmp_i` at 0 or 3 and `mode_i` at 0, each lane returns (A+B) mod 2^w, or (A−B) mod 2^w when `sub_i` is 1.
- R3: No carry or borrow crosses a lane boundary. Each lane result is a function of that lane's operand bits only.
- R4: With `mode_i`=1 (signed saturation) and 8-bit lanes, a result above 127 becomes 0x7F and a result below −128 becomes 0x80.
- R5: With `mode_i`=2 (unsigned saturation) and 8-bit lanes, an add that exceeds 255 gives 0xFF and a subtract that goes below 0 gives 0x00.
- R6: With `mode_i`=1 and 16-bit lanes, results are clamped to the range 0x8000 to 0x7FFF.
- R7: With `mode_i`=2 and 16-bit lanes, an add is clamped to 0xFFFF and a subtract is clamped to 0x0000.
- R8: A saturating mode requested with 32-bit lanes gives the wrap-around result. `mode_i`=3 always gives the wrap-around result.
- R9: With `cmp_i`=1, each lane is all ones when A equals B in that lane, and all zeros otherwise.
- R10: With `cmp_i`=2, each lane is all ones when A is greater than B as signed two's complement, and all zeros otherwise.
- R11: While `cmp_i` is 1 or 2, `mode_i` and `sub_i` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 64 | Operand A (minuend for subtract) |
| b_i | input | 64 | Operand B |
| lane_sel_i | input | 2 | Lane size: 0=8, 1=16, 2/3=32 bits |
| sub_i | input | 1 | 1 selects A−B, 0 selects A+B |
| mode_i | input | 2 | 0 wrap, 1 signed saturate, 2 unsigned saturate, 3 wrap |
| cmp_i | input | 2 | 0/3 arithmetic, 1 equality mask, 2 signed greater-than mask |
| result_o | output | 64 | Registered lane result |

## Verification
The hardest cases to reach from the ports need a lane to overflow or underflow right at its top byte while the lane next to it holds an unrelated value. Only then does a carry leaking across the boundary, or a clamp applied to the wrong lane, become visible. Directed vectors therefore put a clamping lane beside a non-clamping lane for each lane size and mode. They also put 0xFF chains in every byte so that cut carries show up at once. A pseudo-random sweep over every combination of lane size, mode, direction and compare is then checked against a per-lane arithmetic model.

// File: rtl/psat_pkg.sv
package psat_pkg;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_BYTES = DATA_W / BYTE_W;

  typedef enum logic [1:0] {
    LANE_B8   = 2'd0,
    LANE_B16  = 2'd1,
    LANE_B32  = 2'd2,
    LANE_RSVD = 2'd3
  } lane_e;

  typedef enum logic [1:0] {
    ARITH_WRAP = 2'd0,
    ARITH_SSAT = 2'd1,
    ARITH_USAT = 2'd2,
    ARITH_RSVD = 2'd3
  } arith_e;

  typedef enum logic [1:0] {
    CMP_OFF  = 2'd0,
    CMP_EQ   = 2'd1,
    CMP_GT   = 2'd2,
    CMP_RSVD = 2'd3
  } cmp_e;

  // per-byte copy of the flags of the lane the byte belongs to
  typedef struct packed {
    logic cout;  // unsigned carry out of lane top
    logic ovf;   // signed overflow at lane top
    logic neg;   // sign bit of raw lane sum
    logic zero;  // whole raw lane sum is zero
    logic top;   // this byte holds the lane sign
  } lane_flags_t;
endpackage

// File: rtl/psat_seg_adder.sv
module psat_seg_adder #(
  parameter int unsigned NB     = psat_pkg::NUM_BYTES,
  parameter int unsigned BYTE_W = psat_pkg::BYTE_W
) (
  input  logic [NB*BYTE_W-1:0] a_i,
  input  logic [NB*BYTE_W-1:0] b_i,
  input  logic                 sub_i,
  input  logic [NB-1:1]        seg_start_i,
  output logic [NB*BYTE_W-1:0] sum_o,
  output logic [NB-1:0]        cout_o,
  output logic [NB-1:0]        ovf_o
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [BYTE_W-1:0] op_a, op_b;
    logic              cin;
    logic [BYTE_W:0]   tot;

    assign op_a = a_i[g*BYTE_W +: BYTE_W];
    assign op_b = b_i[g*BYTE_W +: BYTE_W] ^ {BYTE_W{sub_i}};

    if (g == 0) begin : g_first
      assign cin = sub_i;
    end else begin : g_chain
      // cut the chain at a lane start; inject the subtract +1 there
      assign cin = seg_start_i[g] ? sub_i : cout_o[g-1];
    end

    assign tot = {1'b0, op_a} + {1'b0, op_b} + {{BYTE_W{1'b0}}, cin};
    assign sum_o[g*BYTE_W +: BYTE_W] = tot[BYTE_W-1:0];
    assign cout_o[g] = tot[BYTE_W];
    assign ovf_o[g]  = (op_a[BYTE_W-1] == op_b[BYTE_W-1]) &&
                       (tot[BYTE_W-1] != op_a[BYTE_W-1]);
  end
endmodule

// File: rtl/psat_lane_ctl.sv
module psat_lane_ctl
  import psat_pkg::*;
#(
  parameter int unsigned NB     = psat_pkg::NUM_BYTES,
  parameter int unsigned BYTE_W = psat_pkg::BYTE_W
) (
  input  lane_e                 lane_i,
  input  logic [NB*BYTE_W-1:0]  sum_i,
  input  logic [NB-1:0]         cout_i,
  input  logic [NB-1:0]         ovf_i,
  output logic [NB-1:1]         seg_start_o,
  output lane_flags_t [NB-1:0]  flags_o
);
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;

  logic [IDX_W-1:0] span_m;
  logic [NB-1:0]    byte_zero;

  always_comb begin
    unique case (lane_i)
      LANE_B8:  span_m = IDX_W'(0);
      LANE_B16: span_m = IDX_W'(1);
      default:  span_m = IDX_W'(3);
    endcase
  end

  for (genvar g = 0; g < NB; g++) begin : g_zero
    assign byte_zero[g] = ~|sum_i[g*BYTE_W +: BYTE_W];
  end

  for (genvar g = 0; g < NB; g++) begin : g_flags
    logic [IDX_W-1:0] my_idx, top_idx, base_idx;
    logic             lane_zero;

    assign my_idx   = IDX_W'(g);
    assign top_idx  = my_idx | span_m;
    assign base_idx = my_idx & ~span_m;

    if (g > 0) begin : g_start
      assign seg_start_o[g] = ((my_idx & span_m) == '0);
    end

    always_comb begin
      lane_zero = 1'b1;
      for (int j = 0; j < int'(NB); j++) begin
        if ((IDX_W'(j) >= base_idx) && (IDX_W'(j) <= top_idx))
          lane_zero = lane_zero & byte_zero[j];
      end
    end

    assign flags_o[g].cout = cout_i[top_idx];
    assign flags_o[g].ovf  = ovf_i[top_idx];
    assign flags_o[g].neg  = sum_i[top_idx*BYTE_W + BYTE_W - 1];
    assign flags_o[g].zero = lane_zero;
    assign flags_o[g].top  = (my_idx == top_idx);
  end
endmodule

// File: rtl/psat_byte_mux.sv
module psat_byte_mux
  import psat_pkg::*;
#(
  parameter int unsigned NB     = psat_pkg::NUM_BYTES,
  parameter int unsigned BYTE_W = psat_pkg::BYTE_W
) (
  input  logic [NB*BYTE_W-1:0]  sum_i,
  input  lane_flags_t [NB-1:0]  flags_i,
  input  arith_e                mode_i,
  input  logic                  sub_i,
  input  cmp_e                  cmp_i,
  output logic [NB*BYTE_W-1:0]  res_o
);
  localparam logic [BYTE_W-1:0] ONES   = {BYTE_W{1'b1}};
  localparam logic [BYTE_W-1:0] POS_HI = {1'b0, {(BYTE_W-1){1'b1}}};
  localparam logic [BYTE_W-1:0] NEG_HI = {1'b1, {(BYTE_W-1){1'b0}}};

  for (genvar g = 0; g < NB; g++) begin : g_byte
    lane_flags_t       f;
    logic              gt;
    logic [BYTE_W-1:0] raw, res;

    assign f   = flags_i[g];
    assign raw = sum_i[g*BYTE_W +: BYTE_W];
    // A-B computed: A<B iff sign xor overflow
    assign gt  = ~(f.neg ^ f.ovf) & ~f.zero;

    always_comb begin
      res = raw;
      unique case (cmp_i)
        CMP_EQ: res = {BYTE_W{f.zero}};
        CMP_GT: res = {BYTE_W{gt}};
        default: begin
          unique case (mode_i)
            ARITH_SSAT: begin
              // overflow with negative raw sign means the true result was positive
              if (f.ovf) res = f.neg ? (f.top ? POS_HI : ONES)
                                     : (f.top ? NEG_HI : '0);
            end
            ARITH_USAT: begin
              if (!sub_i && f.cout)     res = ONES;
              else if (sub_i && !f.cout) res = '0;
            end
            default: res = raw;
          endcase
        end
      endcase
    end

    assign res_o[g*BYTE_W +: BYTE_W] = res;
  end
endmodule

// File: rtl/psat_addsub_unit.sv
module psat_addsub_unit
  import psat_pkg::*;
#(
  parameter int unsigned DATA_W = psat_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        lane_sel_i,
  input  logic              sub_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        cmp_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned NB = DATA_W / psat_pkg::BYTE_W;

  lane_e                lane;
  arith_e               mode_eff;
  cmp_e                 cmp;
  logic                 sub_eff;
  logic [NB-1:1]        seg_start;
  logic [DATA_W-1:0]    sum;
  logic [NB-1:0]        cout_b, ovf_b;
  lane_flags_t [NB-1:0] flags;
  logic [DATA_W-1:0]    res_d, res_q;

  assign lane    = lane_e'(lane_sel_i);
  assign cmp     = cmp_e'(cmp_i);
  // compares run the subtractor
  assign sub_eff = sub_i | (cmp == CMP_EQ) | (cmp == CMP_GT);

  always_comb begin
    mode_eff = arith_e'(mode_i);
    if (mode_eff == ARITH_RSVD || !(lane == LANE_B8 || lane == LANE_B16))
      mode_eff = ARITH_WRAP;
  end

  psat_seg_adder #(.NB(NB)) u_adder (
    .a_i         (a_i),
    .b_i         (b_i),
    .sub_i       (sub_eff),
    .seg_start_i (seg_start),
    .sum_o       (sum),
    .cout_o      (cout_b),
    .ovf_o       (ovf_b)
  );

  psat_lane_ctl #(.NB(NB)) u_lane (
    .lane_i      (lane),
    .sum_i       (sum),
    .cout_i      (cout_b),
    .ovf_i       (ovf_b),
    .seg_start_o (seg_start),
    .flags_o     (flags)
  );

  psat_byte_mux #(.NB(NB)) u_mux (
    .sum_i   (sum),
    .flags_i (flags),
    .mode_i  (mode_eff),
    .sub_i   (sub_i),
    .cmp_i   (cmp),
    .res_o   (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_d;
  end

  assign result_o = res_q;
endmodule

// File: rtl/psat_addsub_chk.sv
module psat_addsub_chk #(
  parameter int unsigned DATA_W = psat_pkg::DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [1:0]        lane_sel_i,
  input logic              sub_i,
  input logic [1:0]        mode_i,
  input logic [1:0]        cmp_i,
  input logic [DATA_W-1:0] result_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) p_reset_zero_r1: assert (result_o == '0);
  end

  p_wrap_identity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(cmp_i == 2'd0 && mode_i == 2'd0 && b_i == '0)
    |-> result_o == $past(a_i));

  p_byte_isolated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(cmp_i == 2'd0 && mode_i == 2'd0 && lane_sel_i == 2'd0 && !sub_i)
    |-> result_o[15:8] == $past(a_i[15:8] + b_i[15:8]));

  p_usat_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(cmp_i == 2'd0 && mode_i == 2'd2 && lane_sel_i == 2'd0 && sub_i && a_i == '0)
    |-> result_o == '0);

  p_sat32_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(cmp_i == 2'd0 && lane_sel_i == 2'd2 && b_i == '0)
    |-> result_o == $past(a_i));

  p_eq_self_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(cmp_i == 2'd1 && a_i == b_i)
    |-> result_o == {DATA_W{1'b1}});

  p_gt_self_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(cmp_i == 2'd2 && a_i == b_i)
    |-> result_o == '0);
endmodule

bind psat_addsub_unit psat_addsub_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .a_i        (a_i),
  .b_i        (b_i),
  .lane_sel_i (lane_sel_i),
  .sub_i      (sub_i),
  .mode_i     (mode_i),
  .cmp_i      (cmp_i),
  .result_o   (result_o)
);

// File: tb/psat_addsub_unit_tb_top.sv
`timescale 1ns/1ps
module psat_addsub_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic [1:0]  lane = '0, mode = '0, cmp = '0;
  logic        sub = 1'b0;
  logic [63:0] res;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  psat_addsub_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .lane_sel_i(lane),
    .sub_i(sub), .mode_i(mode), .cmp_i(cmp), .result_o(res)
  );

  function automatic logic [63:0] model(logic [63:0] ma, logic [63:0] mb, logic [1:0] ml,
                                        logic ms, logic [1:0] mm, logic [1:0] mc);
    int w, n, eff;
    logic [63:0] out;
    longint mask, ua, ub, sa, sb, r, lo, hi;
    w = (ml == 2'd0) ? 8 : (ml == 2'd1) ? 16 : 32;
    n = 64 / w;
    mask = (64'sd1 <<< w) - 1;
    eff = (w == 32 || mm == 2'd3) ? 0 : int'(mm);
    out = '0;
    for (int i = 0; i < n; i++) begin
      ua = longint'((ma >> (i*w))) & mask;
      ub = longint'((mb >> (i*w))) & mask;
      sa = ua[w-1] ? ua - (mask + 1) : ua;
      sb = ub[w-1] ? ub - (mask + 1) : ub;
      if (mc == 2'd1)      r = (ua == ub) ? mask : 0;
      else if (mc == 2'd2) r = (sa > sb) ? mask : 0;
      else if (eff == 1) begin
        r = ms ? sa - sb : sa + sb;
        hi = (mask >>> 1);
        lo = -hi - 1;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
      end else if (eff == 2) begin
        r = ms ? ua - ub : ua + ub;
        if (r > mask) r = mask;
        if (r < 0) r = 0;
      end else r = ms ? ua - ub : ua + ub;
      out = out | (64'(r & mask) << (i*w));
    end
    return out;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [63:0] ta, logic [63:0] tb, logic [1:0] tl,
                       logic ts, logic [1:0] tm, logic [1:0] tc);
    @(negedge clk);
    a = ta; b = tb; lane = tl; sub = ts; mode = tm; cmp = tc;
    @(posedge clk);
    #1;
  endtask

  task automatic run_vec(string tag, logic [63:0] ta, logic [63:0] tb, logic [1:0] tl,
                         logic ts, logic [1:0] tm, logic [1:0] tc, logic [63:0] exp);
    apply(ta, tb, tl, ts, tm, tc);
    check(tag, res, exp);
    check({tag, " model"}, res, model(ta, tb, tl, ts, tm, tc));
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0;
    a = 64'h1; b = 64'h1;
    #7;
    check("R1 reset", res, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    run_vec("R1 latency", 64'h5, 64'h3, 2'd0, 1'b0, 2'd0, 2'd0, 64'h8);
  endtask

  task automatic t_wrap_r2();
    run_vec("R2 sub32", 64'h00000000_00000005, 64'h00000001_00000007,
            2'd2, 1'b1, 2'd0, 2'd0, 64'hFFFFFFFF_FFFFFFFE);
    run_vec("R2 add16", 64'h8000_0001_FFFF_1234, 64'h8000_0002_0001_1111,
            2'd1, 1'b0, 2'd0, 2'd3, 64'h0000_0003_0000_2345);
  endtask

  task automatic t_isolation_r3();
    run_vec("R3 byte", {8{8'hFF}}, {8{8'h01}}, 2'd0, 1'b0, 2'd0, 2'd0, 64'h0);
    run_vec("R3 word", {4{16'h00FF}}, {4{16'h0001}}, 2'd1, 1'b0, 2'd0, 2'd0, {4{16'h0100}});
    run_vec("R3 borrow", 64'h0, {2{32'h00000001}}, 2'd2, 1'b1, 2'd0, 2'd0, {2{32'hFFFFFFFF}});
  endtask

  task automatic t_sat8_r4_r5();
    run_vec("R4 ssat8", 64'h0000_0000_0010_807F, 64'h0000_0000_0020_FF01,
            2'd0, 1'b0, 2'd1, 2'd0, 64'h0000_0000_0030_807F);
    run_vec("R4 ssat8 sub", 64'h0000_0000_0000_7F80, 64'h0000_0000_0000_FF01,
            2'd0, 1'b1, 2'd1, 2'd0, 64'h0000_0000_0000_7F80);
    run_vec("R5 usat8 add", {8{8'hF0}}, {4{16'h2001}}, 2'd0, 1'b0, 2'd2, 2'd0, {4{16'hFFF1}});
    run_vec("R5 usat8 sub", {8{8'h01}}, {4{16'h0200}}, 2'd0, 1'b1, 2'd2, 2'd0, {4{16'h0001}});
  endtask

  task automatic t_sat16_r6_r7();
    run_vec("R6 ssat16", 64'h1234_1234_7FFF_8000, 64'h0234_0234_FFFF_0001,
            2'd1, 1'b1, 2'd1, 2'd0, 64'h1000_1000_7FFF_8000);
    run_vec("R7 usat16 add", 64'h0001_0001_FFF0_FFF0, 64'h0001_00FF_0020_0010,
            2'd1, 1'b0, 2'd2, 2'd0, 64'h0002_0100_FFFF_FFFF);
    run_vec("R7 usat16 sub", 64'h0100_0010_0010_0010, 64'h0001_0010_0011_0020,
            2'd1, 1'b1, 2'd2, 2'd0, 64'h00FF_0000_0000_0000);
  endtask

  task automatic t_fallback_r8();
    run_vec("R8 ssat32", 64'h7FFFFFFF_FFFFFFFF, 64'h00000001_00000001,
            2'd2, 1'b0, 2'd1, 2'd0, 64'h80000000_00000000);
    run_vec("R8 usat32", 64'h0, 64'h00000001_00000000, 2'd3, 1'b1, 2'd2, 2'd0, 64'hFFFFFFFF_00000000);
    run_vec("R8 mode3", {8{8'h7F}}, {8{8'h01}}, 2'd0, 1'b0, 2'd3, 2'd0, {8{8'h80}});
  endtask

  task automatic t_compare_r9_r10_r11();
    run_vec("R9 eq16", 64'h1111_2222_3333_4444, 64'h1111_2223_3333_0000,
            2'd1, 1'b0, 2'd0, 2'd1, 64'hFFFF_0000_FFFF_0000);
    run_vec("R9 eq32", 64'h00000000_DEADBEEF, 64'h00000001_DEADBEEF,
            2'd2, 1'b0, 2'd0, 2'd1, 64'h00000000_FFFFFFFF);
    run_vec("R10 gt8", 64'h0000_0000_0005_8001, 64'h0000_0000_0005_7FFF,
            2'd0, 1'b0, 2'd0, 2'd2, 64'h0000_0000_0000_00FF);
    run_vec("R10 gt32", 64'h80000000_00000001, 64'h7FFFFFFF_80000000,
            2'd2, 1'b0, 2'd0, 2'd2, 64'h00000000_FFFFFFFF);
    run_vec("R11 eq mode", 64'h1111_2222_3333_4444, 64'h1111_2223_3333_0000,
            2'd1, 1'b0, 2'd1, 2'd1, 64'hFFFF_0000_FFFF_0000);
    run_vec("R11 gt sub", 64'h0000_0000_0005_8001, 64'h0000_0000_0005_7FFF,
            2'd0, 1'b1, 2'd2, 2'd2, 64'h0000_0000_0000_00FF);
  endtask

  task automatic t_sweep();
    logic [63:0] lf = 64'hACE1_2468_1357_9BDF;
    logic [63:0] ra, rb;
    for (int i = 0; i < 768; i++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      ra = lf;
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      rb = (i % 5 == 0) ? ra ^ (lf & 64'h00FF_0000_FFFF_0000) : lf;
      apply(ra, rb, 2'(i % 4), 1'((i / 4) % 2), 2'((i / 8) % 4), 2'((i / 32) % 4));
      check((cmp == 2'd1) ? "R9 sweep" : (cmp == 2'd2) ? "R10 sweep" : "R2 R4 R5 R6 R7 R8 sweep",
            res, model(ra, rb, lane, sub, mode, cmp));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset_r1();
    t_wrap_r2();
    t_isolation_r3();
    t_sat8_r4_r5();
    t_sat16_r6_r7();
    t_fallback_r8();
    t_compare_r9_r10_r11();
    t_sweep();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule